// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Fall-Through

This block is a first-in first-out buffer whose write port and read port run on separate clocks. Words enter on the write clock and leave on the read clock. The read and write pointers cross between the clock domains as Gray codes through a chain of synchronizer flops. Each side has one status pin. The meaning of that pin depends on an operating mode that is captured while master reset is held.

In standard mode, every stored word stays in memory until a read is accepted. The read-side pin then reports that the FIFO is empty, and the write-side pin reports that it is full. In fall-through mode, an output register holds the head word. The oldest stored word moves into that register without any read request. The read-side pin reports that the output is valid, and the write-side pin reports that space is free. In this mode a read consumes the word currently shown and then loads the next one. If no word is waiting, the read clears the valid indication instead.

There are two resets. Master reset rewinds both pointers and recaptures the mode. Partial reset rewinds the pointers and empties the output stage, but the captured mode stays unchanged, so the buffer can be flushed without configuring it again.

Top module: `dcf_top`

## Requirements
- R1: The mode (mode_sel low selects standard, high selects fall-through) is sampled on every clock edge at which mrst is high. Changes on mode_sel at other times have no effect.
- R2: In standard mode, rflag is high when the FIFO is empty. rdata changes only on the read-clock edge that accepts a read, and after that edge it carries the oldest stored word.
- R3: In fall-through mode, rflag high means rdata carries a valid head word, and this needs no read request. A read while rflag is high consumes that word. On the same edge the next stored word is loaded, or rflag falls if no word is stored.
- R4: wflag is high when the memory is full in standard mode. In fall-through mode wflag is high when space is available, which is the inverse of full.
- R5: With the default two synchronizer stages, a word written into an empty FIFO clears the standard-mode empty flag on the third read-clock edge after the write edge. In fall-through mode, rflag rises on the fourth edge.
- R6: A write is ignored while the memory is full. Standard mode accepts exactly DEPTH words. Fall-through mode accepts DEPTH+1 words, because the output register holds one more.
- R7: A read is ignored while the FIFO is empty (standard mode) or while no word is shown (fall-through mode). rdata keeps its value and no word is lost.
- R8: Partial reset (prst high) empties the FIFO, clears rdata to zero and drops rflag in fall-through mode, but keeps the captured mode.
- R9: After master reset, rdata is zero. In standard mode rflag is high and wflag is low. In fall-through mode rflag is low and wflag is high.
- R10: Words are read out in the order they were written, and their values are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst | input | 1 | Master reset, active high, synchronous to both clocks |
| prst | input | 1 | Partial reset, active high, synchronous to both clocks |
| mode_sel | input | 1 | Mode select, captured during master reset (1 = fall-through) |
| wen | input | 1 | Write request |
| wdata | input | DATA_W | Write data |
| wflag | output | 1 | Full (standard mode) or input-ready (fall-through mode) |
| ren | input | 1 | Read request |
| rdata | output | DATA_W | Read data / head word |
| rflag | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |

## Verification
The assertions assume two things about the inputs:
- Both resets are held for at least as many edges of each clock as there are synchronizer stages.
- Both clocks run while a reset is high, so that the mode and the cleared state reach every flop.

The bench meets both conditions by driving the two ports from one clock and by holding each reset for at least two edges. It changes inputs only at falling edges. Its randomized phase keeps requesting writes while the FIFO is full and reads while it is empty, and it toggles mode_sel outside reset. This keeps the ignore paths and the mode hold continuously exercised.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
   typedef enum logic {
      DCF_STD = 1'b0,
      DCF_FT  = 1'b1
   } dcf_mode_e;

   localparam int DCF_MAX_PTR = 32;

   function automatic logic [DCF_MAX_PTR-1:0] dcf_to_gray(input logic [DCF_MAX_PTR-1:0] b);
      return b ^ (b >> 1);
   endfunction
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
   parameter int WIDTH  = 9,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             clr,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (clr) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 8
) (
   input  logic              wclk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [WORDS];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
   import dcf_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              mode_sel,
   input  logic              wen,
   input  logic [ADDR_W:0]   rgray_s,
   output logic [ADDR_W:0]   wgray,
   output logic [ADDR_W-1:0] waddr,
   output logic              wr_acc,
   output logic              wflag
);
   localparam int PTR_W = ADDR_W + 1;

   dcf_mode_e        mode_q;
   logic [PTR_W-1:0] wbin, wbin_nx, wgray_nx, full_pat;
   logic             full_q, full_nx, clr;

   assign clr = mrst | prst;

   always_ff @(posedge clk) begin
      if (mrst) mode_q <= dcf_mode_e'(mode_sel);
   end

   assign wr_acc   = wen & ~full_q;
   assign wbin_nx  = wbin + PTR_W'(wr_acc);
   assign wgray_nx = PTR_W'(dcf_to_gray(DCF_MAX_PTR'(wbin_nx)));
   assign full_pat = {~rgray_s[ADDR_W:ADDR_W-1], rgray_s[ADDR_W-2:0]};
   assign full_nx  = (wgray_nx == full_pat);

   always_ff @(posedge clk) begin
      if (clr) begin
         wbin   <= '0;
         wgray  <= '0;
         full_q <= 1'b0;
      end else begin
         wbin   <= wbin_nx;
         wgray  <= wgray_nx;
         full_q <= full_nx;
      end
   end

   assign waddr = wbin[ADDR_W-1:0];
   assign wflag = (mode_q == DCF_FT) ? ~full_q : full_q;

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (clr)
      full_q |=> $stable(wbin));

   // R1
   wr_mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
      !mrst |=> $stable(mode_q));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
   import dcf_pkg::*;
#(
   parameter int DATA_W = 36,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              mode_sel,
   input  logic              ren,
   input  logic [ADDR_W:0]   wgray_s,
   input  logic [DATA_W-1:0] mem_q,
   output logic [ADDR_W:0]   rgray,
   output logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              rflag
);
   localparam int PTR_W = ADDR_W + 1;

   dcf_mode_e         mode_q;
   logic [PTR_W-1:0]  rbin, rbin_nx, rgray_nx;
   logic              empty_q, empty_nx, ovalid, pop, clr;
   logic [DATA_W-1:0] out_q;

   assign clr = mrst | prst;

   always_ff @(posedge clk) begin
      if (mrst) mode_q <= dcf_mode_e'(mode_sel);
   end

   always_comb begin
      if (mode_q == DCF_FT) pop = ~empty_q & (~ovalid | ren);
      else                  pop = ren & ~empty_q;
   end

   assign rbin_nx  = rbin + PTR_W'(pop);
   assign rgray_nx = PTR_W'(dcf_to_gray(DCF_MAX_PTR'(rbin_nx)));
   assign empty_nx = (rgray_nx == wgray_s);

   always_ff @(posedge clk) begin
      if (clr) begin
         rbin    <= '0;
         rgray   <= '0;
         empty_q <= 1'b1;
         ovalid  <= 1'b0;
         out_q   <= '0;
      end else begin
         rbin    <= rbin_nx;
         rgray   <= rgray_nx;
         empty_q <= empty_nx;
         if (pop) begin
            out_q  <= mem_q;
            ovalid <= 1'b1;
         end else if (ren) begin
            ovalid <= 1'b0;
         end
      end
   end

   assign raddr = rbin[ADDR_W-1:0];
   assign rdata = out_q;
   assign rflag = (mode_q == DCF_FT) ? ovalid : empty_q;

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (clr)
      empty_q |=> $stable(rbin));

   // R2
   std_hold_chk: assert property (@(posedge clk) disable iff (clr)
      (mode_q == DCF_STD) && !(ren && !empty_q) |=> $stable(out_q));

   // R3
   ft_head_hold_chk: assert property (@(posedge clk) disable iff (clr)
      (mode_q == DCF_FT) && ovalid && !ren |=> ovalid && $stable(out_q));

   // R1
   rd_mode_hold_chk: assert property (@(posedge clk) disable iff (mrst)
      !mrst |=> $stable(mode_q));
endmodule

// File: rtl/dcf_top.sv
module dcf_top #(
   parameter int DATA_W      = 36,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic              wclk,
   input  logic              rclk,
   input  logic              mrst,
   input  logic              prst,
   input  logic              mode_sel,
   input  logic              wen,
   input  logic [DATA_W-1:0] wdata,
   output logic              wflag,
   input  logic              ren,
   output logic [DATA_W-1:0] rdata,
   output logic              rflag
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int PTR_W  = ADDR_W + 1;

   generate
      if (DEPTH != (1 << ADDR_W) || DEPTH < 4) begin : g_bad_depth
         $error("dcf_top: DEPTH must be a power of two of at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dcf_top: SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("dcf_top: DATA_W must be positive");
      end
   endgenerate

   logic [PTR_W-1:0]  wgray, rgray, wgray_s, rgray_s;
   logic [ADDR_W-1:0] waddr, raddr;
   logic [DATA_W-1:0] mem_q;
   logic              wr_acc;
   logic              clr;

   assign clr = mrst | prst;

   dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
      .clk(wclk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel), .wen(wen),
      .rgray_s(rgray_s), .wgray(wgray), .waddr(waddr), .wr_acc(wr_acc),
      .wflag(wflag)
   );

   dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .wclk(wclk), .we(wr_acc), .waddr(waddr), .wdata(wdata),
      .raddr(raddr), .rdata(mem_q)
   );

   dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rclk), .clr(clr), .din(wgray), .dout(wgray_s)
   );

   dcf_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wclk), .clr(clr), .din(rgray), .dout(rgray_s)
   );

   dcf_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .clk(rclk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel), .ren(ren),
      .wgray_s(wgray_s), .mem_q(mem_q), .rgray(rgray), .raddr(raddr),
      .rdata(rdata), .rflag(rflag)
   );
endmodule

// File: tb/dcf_top_tb.sv
`timescale 1ns/1ps
module dcf_top_tb;
   localparam int DW    = 36;
   localparam int DEPTH = 256;

   logic          clk = 1'b0;
   logic          mrst = 1'b0, prst = 1'b0, mode_sel = 1'b0;
   logic          wen = 1'b0, ren = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          wflag, rflag;

   int tests = 0, fails = 0;
   bit done = 0;

   always #2 clk = ~clk;

   dcf_top #(.DATA_W(DW), .DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
      .wclk(clk), .rclk(clk), .mrst(mrst), .prst(prst), .mode_sel(mode_sel),
      .wen(wen), .wdata(wdata), .wflag(wflag), .ren(ren), .rdata(rdata),
      .rflag(rflag)
   );

   // Behavioural reference: integer pointers, delayed copies, keyed store
   bit            m_live = 0, m_ft = 0, m_full = 0, m_empty = 1, m_ov = 0;
   int            wp = 0, rp = 0, wq1 = 0, wq2 = 0, rq1 = 0, rq2 = 0;
   logic [DW-1:0] m_rdata = '0;
   logic [DW-1:0] store [int];

   task automatic m_clear();
      wp = 0; rp = 0; wq1 = 0; wq2 = 0; rq1 = 0; rq2 = 0;
      m_full = 0; m_empty = 1; m_ov = 0; m_rdata = '0;
      store.delete();
   endtask

   always @(posedge clk) begin
      if (mrst) begin
         m_ft = mode_sel; m_clear(); m_live = 0;
      end else if (prst) begin
         m_clear(); m_live = 0;
      end else begin
         bit wacc, pop, full_n, empty_n, ov_n;
         int wp_n, rp_n;
         wacc = wen && !m_full;
         wp_n = wp + (wacc ? 1 : 0);
         if (wacc) store[wp] = wdata;
         full_n = ((wp_n - rq2) == DEPTH);
         if (m_ft) pop = !m_empty && (!m_ov || ren);
         else      pop = ren && !m_empty;
         rp_n = rp + (pop ? 1 : 0);
         empty_n = (rp_n == wq2);
         ov_n = m_ov;
         if (pop) begin
            m_rdata = store[rp];
            ov_n = 1;
         end else if (ren) begin
            ov_n = 0;
         end
         rq2 = rq1; rq1 = rp; wq2 = wq1; wq1 = wp;
         wp = wp_n; rp = rp_n; m_full = full_n; m_empty = empty_n; m_ov = ov_n;
         m_live = 1;
      end
   end

   task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (m_live && !done) begin
         chk(DW'(rflag), DW'(m_ft ? m_ov : m_empty), m_ft ? "R3 rflag" : "R2 rflag");
         chk(DW'(wflag), DW'(m_ft ? !m_full : m_full), "R4 wflag");
         chk(rdata, m_rdata, "R10 rdata");
      end
   end

   task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r);
      wen = w; wdata = d; ren = r;
      @(negedge clk);
   endtask

   task automatic do_mrst(input logic md);
      wen = 0; ren = 0; mrst = 1; mode_sel = md;
      repeat (3) @(negedge clk);
      mrst = 0;
   endtask

   task automatic do_prst();
      wen = 0; ren = 0; prst = 1;
      repeat (2) @(negedge clk);
      prst = 0;
   endtask

   initial begin
      #600000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int acc;
      @(negedge clk);

      // R9 reset state, standard
      do_mrst(1'b0);
      chk(DW'(rflag), DW'(1), "R9 std rflag");
      chk(DW'(wflag), DW'(0), "R9 std wflag");
      chk(rdata, '0, "R9 std rdata");

      // R5 flag latency, standard
      cyc(1, 36'hA_1234_5678, 0);
      chk(DW'(rflag), DW'(1), "R5 edge1");
      cyc(0, '0, 0);
      chk(DW'(rflag), DW'(1), "R5 edge2");
      cyc(0, '0, 0);
      chk(DW'(rflag), DW'(1), "R5 edge3-1");
      cyc(0, '0, 0);
      chk(DW'(rflag), DW'(0), "R5 edge3");
      cyc(0, '0, 0);
      chk(rdata, '0, "R2 no read no data");
      cyc(0, '0, 1);
      chk(rdata, 36'hA_1234_5678, "R2 read data");
      chk(DW'(rflag), DW'(1), "R2 empty again");
      cyc(0, '0, 1);
      cyc(0, '0, 1);
      chk(rdata, 36'hA_1234_5678, "R7 read on empty ignored");

      // R1 R3 R5 fall-through: mode_sel changes after reset
      do_mrst(1'b1);
      chk(DW'(rflag), DW'(0), "R9 ft rflag");
      chk(DW'(wflag), DW'(1), "R9 ft wflag");
      mode_sel = 0;
      cyc(1, 36'h5_0000_00B0, 0);
      cyc(0, '0, 0);
      cyc(0, '0, 0);
      cyc(0, '0, 0);
      chk(DW'(rflag), DW'(0), "R5 ft edge3");
      cyc(0, '0, 0);
      chk(DW'(rflag), DW'(1), "R5 ft edge4");
      chk(rdata, 36'h5_0000_00B0, "R3 fall-through head");
      chk(DW'(rflag), DW'(1), "R1 mode kept after mode_sel change");
      cyc(0, '0, 1);
      chk(DW'(rflag), DW'(0), "R3 read clears ready");
      cyc(0, '0, 1);
      chk(rdata, 36'h5_0000_00B0, "R7 ft read without data ignored");

      // R6 fill standard
      do_mrst(1'b0);
      acc = 0;
      for (int i = 0; i < 300; i++) begin
         if (!wflag) acc++;
         cyc(1, DW'(i + 1000), 0);
      end
      chk(DW'(acc), DW'(DEPTH), "R6 std accepted writes");
      chk(DW'(wflag), DW'(1), "R6 std full");
      acc = 0;
      for (int i = 0; i < 300; i++) begin
         if (!rflag) acc++;
         cyc(0, '0, 1);
      end
      chk(DW'(acc), DW'(DEPTH), "R10 std drained count");
      chk(rdata, DW'(1000 + DEPTH - 1), "R10 std last word");

      // R6 fill fall-through
      do_mrst(1'b1);
      acc = 0;
      for (int i = 0; i < 300; i++) begin
         if (wflag) acc++;
         cyc(1, DW'(i + 5000), 0);
      end
      chk(DW'(acc), DW'(DEPTH + 1), "R6 ft accepted writes");
      chk(DW'(wflag), DW'(0), "R6 ft not ready");
      acc = 0;
      for (int i = 0; i < 300; i++) begin
         if (rflag) acc++;
         cyc(0, '0, 1);
      end
      chk(DW'(acc), DW'(DEPTH + 1), "R10 ft drained count");

      // R8 partial reset keeps fall-through
      for (int i = 0; i < 10; i++) cyc(1, DW'(i + 77), 0);
      repeat (6) cyc(0, '0, 0);
      mode_sel = 0;
      do_prst();
      cyc(0, '0, 0);
      chk(DW'(rflag), DW'(0), "R8 flushed rflag");
      chk(DW'(wflag), DW'(1), "R8 ready after flush");
      chk(rdata, '0, "R8 rdata cleared");
      cyc(1, 36'hC_0C0C_0C0C, 0);
      repeat (4) cyc(0, '0, 0);
      chk(DW'(rflag), DW'(1), "R8 mode kept");
      chk(rdata, 36'hC_0C0C_0C0C, "R8 fall-through after flush");

      // R9 master reset reloads mode
      do_mrst(1'b0);
      chk(DW'(rflag), DW'(1), "R9 back to std");
      chk(DW'(wflag), DW'(0), "R9 std wflag again");

      // R10 random traffic, both modes, mode_sel toggling (R1)
      for (int m = 0; m < 2; m++) begin
         do_mrst(m[0]);
         for (int i = 0; i < 2500; i++) begin
            mode_sel = 1'($urandom);
            cyc(($urandom % 100) < (i < 1200 ? 70 : 35),
                {4'($urandom), 32'($urandom)}, ($urandom % 100) < (i < 1200 ? 35 : 70));
         end
         if (m == 0) do_prst();
      end

      repeat (2) @(negedge clk);
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule